// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Status Generator

This block watches a bank of virtual interrupt list entries and the hypervisor's control enables. From them it derives three things that a hypervisor uses to manage a guest's interrupts. The first is an end-of-interrupt bitmap, which marks the entries that were retired with notification requested. The second is a bitmap of entries that are free for reuse. The third is an eight-bit maintenance cause word. Any enabled cause, when the global virtual enable is set, raises a registered maintenance interrupt toward the hypervisor.

The block also owns the 5-bit end-of-interrupt miss counter. Software may write this counter, but a write can only lower the value or keep it the same. Hardware adds one to the counter each time a deactivate finds no matching list entry. A nonzero count feeds one of the maintenance causes.

List entries arrive as flat vectors: 2 state bits per entry, one hardware-linked bit per entry and one notify bit per entry. Entry i uses bits [2i+1:2i] of the state vector.

Top module: `vmaint_status`

## Requirements
- R1: State encoding: 0 invalid, 1 pending, 2 active, 3 pending and active. Bit i of `eoi_map` is 1 exactly when entry i is invalid, its hardware bit is 0 and its notify bit is 1.
- R2: Bit i of `free_map` is 1 exactly when entry i is invalid and either its hardware bit is 1 or its notify bit is 0.
- R3: `cause[1]` (underflow) is 1 exactly when `en_underflow` is set and fewer than 2 entries have a state other than invalid.
- R4: `cause[3]` (nothing pending) is 1 exactly when `en_nopend` is set and no entry has state 1 or 3.
- R5: `cause[2]` (entry not present) is 1 exactly when `en_notpresent` is set and `eoi_count` is nonzero.
- R6: The group causes are `cause[4]` = `en_g0_on` & `vgrp0_en`, `cause[5]` = `en_g0_off` & !`vgrp0_en`, `cause[6]` = `en_g1_on` & `vgrp1_en` and `cause[7]` = `en_g1_off` & !`vgrp1_en`.
- R7: `cause[0]` (end of interrupt) is 1 exactly when any bit of `eoi_map` is 1. This cause has no enable.
- R8: A count write (`cnt_wr`) takes effect on the next clock only if `cnt_wr_val` is less than or equal to the current `eoi_count`. Otherwise the write is ignored and the count is kept.
- R9: A `deact_miss` pulse adds 1 to the value left after any write in the same cycle. The count saturates at 31.
- R10: `maint_irq` takes, one clock later, the value of `virt_en` AND (any bit of `cause` set).
- R11: Synchronous reset clears `maint_irq` and `eoi_count` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_state | input | 2*NUM_LR | Per-entry state, 2 bits each |
| lr_hw | input | NUM_LR | Per-entry hardware-linked bit |
| lr_notify | input | NUM_LR | Per-entry EOI notify bit |
| virt_en | input | 1 | Global virtual interface enable |
| en_underflow | input | 1 | Underflow cause enable |
| en_nopend | input | 1 | Nothing-pending cause enable |
| en_notpresent | input | 1 | Entry-not-present cause enable |
| en_g0_on | input | 1 | Group 0 enabled cause enable |
| en_g0_off | input | 1 | Group 0 disabled cause enable |
| en_g1_on | input | 1 | Group 1 enabled cause enable |
| en_g1_off | input | 1 | Group 1 disabled cause enable |
| vgrp0_en | input | 1 | Virtual group 0 enable |
| vgrp1_en | input | 1 | Virtual group 1 enable |
| cnt_wr | input | 1 | Software write of the miss count |
| cnt_wr_val | input | CNT_W | Value for the count write |
| deact_miss | input | 1 | Deactivate found no matching entry |
| eoi_map | output | NUM_LR | End-of-interrupt status bitmap |
| free_map | output | NUM_LR | Free-entry bitmap |
| cause | output | 8 | Maintenance cause word |
| eoi_count | output | CNT_W | End-of-interrupt miss count |
| maint_irq | output | 1 | Registered maintenance interrupt |

## Verification
The assertions check four properties on every cycle:
- the two bitmaps never overlap and together cover exactly the invalid entries;
- the end-of-interrupt cause follows the bitmap;
- the counter never climbs except by one step on a miss;
- the interrupt line follows the cause word one clock later.

The exact thresholds can only be shown by the bench's scenarios. These are the underflow edge between one valid entry and two, the rejection of a higher count write, saturation at 31, and a write and a miss landing in the same cycle. The bench's scenarios also check each cause bit against the enable that gates it.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;
  typedef enum logic [1:0] {
    LR_INVALID  = 2'd0,
    LR_PENDING  = 2'd1,
    LR_ACTIVE   = 2'd2,
    LR_PEND_ACT = 2'd3
  } lr_state_e;

  localparam int CAUSE_W  = 8;
  localparam int C_EOI    = 0;
  localparam int C_UNDER  = 1;
  localparam int C_NOTPRS = 2;
  localparam int C_NOPEND = 3;
  localparam int C_G0ON   = 4;
  localparam int C_G0OFF  = 5;
  localparam int C_G1ON   = 6;
  localparam int C_G1OFF  = 7;
endpackage

// File: rtl/vmaint_slot_decode.sv
module vmaint_slot_decode #(
  parameter int NUM_LR = 16
) (
  input  logic [2*NUM_LR-1:0] lr_state,
  input  logic [NUM_LR-1:0]   lr_hw,
  input  logic [NUM_LR-1:0]   lr_notify,
  output logic [NUM_LR-1:0]   eoi_map,
  output logic [NUM_LR-1:0]   free_map,
  output logic [NUM_LR-1:0]   valid_map,
  output logic [NUM_LR-1:0]   pend_map
);
  import vmaint_pkg::*;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_slot
    lr_state_e st;
    logic      inval;
    assign st           = lr_state_e'(lr_state[2*i +: 2]);
    assign inval        = (st == LR_INVALID);
    assign eoi_map[i]   = inval && !lr_hw[i] && lr_notify[i];
    assign free_map[i]  = inval && (lr_hw[i] || !lr_notify[i]);
    assign valid_map[i] = !inval;
    assign pend_map[i]  = (st == LR_PENDING) || (st == LR_PEND_ACT);
  end
endmodule

// File: rtl/vmaint_popcount.sv
module vmaint_popcount #(
  parameter int N = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/vmaint_eoicnt.sv
module vmaint_eoicnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    base = (wr && (wr_val <= cnt)) ? wr_val : cnt;
    nxt  = (inc && (base != CNT_MAX)) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end
endmodule

// File: rtl/vmaint_status.sv
module vmaint_status #(
  parameter int NUM_LR      = 16,
  parameter int CNT_W       = 5,
  parameter int UNDER_LIMIT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*NUM_LR-1:0] lr_state,
  input  logic [NUM_LR-1:0]   lr_hw,
  input  logic [NUM_LR-1:0]   lr_notify,
  input  logic                virt_en,
  input  logic                en_underflow,
  input  logic                en_nopend,
  input  logic                en_notpresent,
  input  logic                en_g0_on,
  input  logic                en_g0_off,
  input  logic                en_g1_on,
  input  logic                en_g1_off,
  input  logic                vgrp0_en,
  input  logic                vgrp1_en,
  input  logic                cnt_wr,
  input  logic [CNT_W-1:0]    cnt_wr_val,
  input  logic                deact_miss,
  output logic [NUM_LR-1:0]   eoi_map,
  output logic [NUM_LR-1:0]   free_map,
  output logic [7:0]          cause,
  output logic [CNT_W-1:0]    eoi_count,
  output logic                maint_irq
);
  import vmaint_pkg::*;

  localparam int POP_W = $clog2(NUM_LR + 1);

  logic [NUM_LR-1:0] valid_map;
  logic [NUM_LR-1:0] pend_map;
  logic [POP_W-1:0]  valid_cnt;
  logic [POP_W-1:0]  pend_cnt;

  vmaint_slot_decode #(.NUM_LR(NUM_LR)) u_dec (
    .lr_state  (lr_state),
    .lr_hw     (lr_hw),
    .lr_notify (lr_notify),
    .eoi_map   (eoi_map),
    .free_map  (free_map),
    .valid_map (valid_map),
    .pend_map  (pend_map)
  );

  vmaint_popcount #(.N(NUM_LR)) u_valid_cnt (.vec(valid_map), .count(valid_cnt));
  vmaint_popcount #(.N(NUM_LR)) u_pend_cnt  (.vec(pend_map),  .count(pend_cnt));

  vmaint_eoicnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .wr     (cnt_wr),
    .wr_val (cnt_wr_val),
    .inc    (deact_miss),
    .cnt    (eoi_count)
  );

  always_comb begin
    cause           = '0;
    cause[C_EOI]    = |eoi_map;
    cause[C_UNDER]  = en_underflow && (valid_cnt < POP_W'(UNDER_LIMIT));
    cause[C_NOTPRS] = en_notpresent && (eoi_count != '0);
    cause[C_NOPEND] = en_nopend && (pend_cnt == '0);
    cause[C_G0ON]   = en_g0_on && vgrp0_en;
    cause[C_G0OFF]  = en_g0_off && !vgrp0_en;
    cause[C_G1ON]   = en_g1_on && vgrp1_en;
    cause[C_G1OFF]  = en_g1_off && !vgrp1_en;
  end

  always_ff @(posedge clk) begin
    if (rst) maint_irq <= 1'b0;
    else     maint_irq <= virt_en && (|cause);
  end
endmodule

// File: rtl/vmaint_status_chk.sv
module vmaint_status_chk #(
  parameter int NUM_LR = 16,
  parameter int CNT_W  = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [2*NUM_LR-1:0] lr_state,
  input logic                virt_en,
  input logic                deact_miss,
  input logic [NUM_LR-1:0]   eoi_map,
  input logic [NUM_LR-1:0]   free_map,
  input logic [7:0]          cause,
  input logic [CNT_W-1:0]    eoi_count,
  input logic                maint_irq
);
  logic [NUM_LR-1:0] inval_slots;
  always_comb begin
    for (int i = 0; i < NUM_LR; i++) inval_slots[i] = (lr_state[2*i +: 2] == 2'd0);
  end

  // R1 R2
  maps_partition_chk: assert property (@(posedge clk) disable iff (rst)
    ((eoi_map & free_map) == '0) && ((eoi_map | free_map) == inval_slots));

  // R7
  eoi_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cause[0] == (eoi_map != '0));

  // R8
  count_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !deact_miss |=> eoi_count <= $past(eoi_count));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    deact_miss |=> {1'b0, eoi_count} <= {1'b0, $past(eoi_count)} + 1'b1);

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> maint_irq == $past(virt_en && (cause != '0)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!maint_irq && eoi_count == '0));
endmodule

bind vmaint_status vmaint_status_chk #(.NUM_LR(NUM_LR), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lr_state   (lr_state),
  .virt_en    (virt_en),
  .deact_miss (deact_miss),
  .eoi_map    (eoi_map),
  .free_map   (free_map),
  .cause      (cause),
  .eoi_count  (eoi_count),
  .maint_irq  (maint_irq)
);

// File: tb/vmaint_status_tb.sv
`timescale 1ns/1ps
module vmaint_status_tb;
  localparam int N = 16;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*N-1:0] lr_state = '0;
  logic [N-1:0] lr_hw = '0, lr_notify = '0;
  logic virt_en = 0, en_underflow = 0, en_nopend = 0, en_notpresent = 0;
  logic en_g0_on = 0, en_g0_off = 0, en_g1_on = 0, en_g1_off = 0;
  logic vgrp0_en = 0, vgrp1_en = 0, cnt_wr = 0, deact_miss = 0;
  logic [CW-1:0] cnt_wr_val = '0;
  logic [N-1:0] eoi_map, free_map;
  logic [7:0] cause;
  logic [CW-1:0] eoi_count;
  logic maint_irq;

  int n_tests = 0, n_fail = 0;
  logic [CW-1:0] m_cnt = '0;

  always #2.5 clk = ~clk;

  vmaint_status u_dut (
    .clk(clk), .rst(rst), .lr_state(lr_state), .lr_hw(lr_hw), .lr_notify(lr_notify),
    .virt_en(virt_en), .en_underflow(en_underflow), .en_nopend(en_nopend),
    .en_notpresent(en_notpresent), .en_g0_on(en_g0_on), .en_g0_off(en_g0_off),
    .en_g1_on(en_g1_on), .en_g1_off(en_g1_off), .vgrp0_en(vgrp0_en), .vgrp1_en(vgrp1_en),
    .cnt_wr(cnt_wr), .cnt_wr_val(cnt_wr_val), .deact_miss(deact_miss),
    .eoi_map(eoi_map), .free_map(free_map), .cause(cause), .eoi_count(eoi_count),
    .maint_irq(maint_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_eoi();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (lr_state[2*i +: 2] == 2'd0) && !lr_hw[i] && lr_notify[i];
    return r;
  endfunction

  function automatic logic [N-1:0] m_free();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (lr_state[2*i +: 2] == 2'd0) && (lr_hw[i] || !lr_notify[i]);
    return r;
  endfunction

  function automatic logic [7:0] m_cause();
    logic [7:0] c;
    int nv = 0, np = 0;
    for (int i = 0; i < N; i++) begin
      if (lr_state[2*i +: 2] != 2'd0) nv++;
      if (lr_state[2*i +: 2] == 2'd1 || lr_state[2*i +: 2] == 2'd3) np++;
    end
    c[0] = (m_eoi() != '0);
    c[1] = en_underflow && (nv < 2);
    c[2] = en_notpresent && (m_cnt != '0);
    c[3] = en_nopend && (np == 0);
    c[4] = en_g0_on && vgrp0_en;
    c[5] = en_g0_off && !vgrp0_en;
    c[6] = en_g1_on && vgrp1_en;
    c[7] = en_g1_off && !vgrp1_en;
    return c;
  endfunction

  function automatic string cause_req(input int b);
    case (b)
      0: return "R7 eoi cause";
      1: return "R3 underflow";
      2: return "R5 not present";
      3: return "R4 nothing pending";
      default: return "R6 group cause";
    endcase
  endfunction

  // Called at a negedge with inputs already applied.
  task automatic run_cycle();
    logic [7:0] ec;
    logic e_irq;
    logic [CW-1:0] base;
    #1;
    ec = m_cause();
    chk(eoi_map == m_eoi(), "R1 eoi_map", 32'(eoi_map), 32'(m_eoi()));
    chk(free_map == m_free(), "R2 free_map", 32'(free_map), 32'(m_free()));
    for (int b = 0; b < 8; b++) chk(cause[b] == ec[b], cause_req(b), 32'(cause[b]), 32'(ec[b]));
    e_irq = virt_en && (ec != 0);
    base = (cnt_wr && cnt_wr_val <= m_cnt) ? cnt_wr_val : m_cnt;
    if (deact_miss && base != 5'd31) base = base + 1'b1;
    m_cnt = base;
    @(posedge clk);
    @(negedge clk);
    chk(maint_irq == e_irq, "R10 maint_irq", 32'(maint_irq), 32'(e_irq));
    chk(eoi_count == m_cnt, "R8 R9 eoi_count", 32'(eoi_count), 32'(m_cnt));
    cnt_wr = 0;
    deact_miss = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(maint_irq == 1'b0, "R11 irq reset", 32'(maint_irq), 0);
    chk(eoi_count == '0, "R11 count reset", 32'(eoi_count), 0);
    rst = 0;

    // R1 R7: only slot 3 retired with notify; others pending
    for (int i = 0; i < N; i++) lr_state[2*i +: 2] = 2'd1;
    lr_state[7:6] = 2'd0; lr_notify = 16'h0008; lr_hw = '0; virt_en = 1;
    run_cycle();
    chk(eoi_map == 16'h0008, "R1 single slot", 32'(eoi_map), 32'h8);
    // R2: hardware bit turns the same slot into a free one
    lr_hw = 16'h0008;
    run_cycle();
    chk(free_map == 16'h0008 && cause[0] == 0, "R2 hw slot free", 32'(free_map), 32'h8);

    // R3: exactly two valid entries -> no underflow; one -> underflow
    lr_state = '0; lr_hw = '0; lr_notify = '0; en_underflow = 1;
    lr_state[1:0] = 2'd2; lr_state[9:8] = 2'd3;
    run_cycle();
    chk(cause[1] == 0, "R3 two valid", 32'(cause[1]), 0);
    lr_state[9:8] = 2'd0;
    run_cycle();
    chk(cause[1] == 1, "R3 one valid", 32'(cause[1]), 1);
    // R4: active only -> nothing pending
    en_nopend = 1;
    run_cycle();
    chk(cause[3] == 1, "R4 active only", 32'(cause[3]), 1);

    // R9: three misses
    en_underflow = 0; en_nopend = 0; en_notpresent = 1; virt_en = 0;
    repeat (3) begin deact_miss = 1; run_cycle(); end
    chk(eoi_count == 5'd3, "R9 three misses", 32'(eoi_count), 3);
    // R5 with count nonzero
    run_cycle();
    chk(cause[2] == 1, "R5 count nonzero", 32'(cause[2]), 1);
    // R8: higher write ignored, lower accepted, equal held
    cnt_wr = 1; cnt_wr_val = 5'd9; run_cycle();
    chk(eoi_count == 5'd3, "R8 raise ignored", 32'(eoi_count), 3);
    cnt_wr = 1; cnt_wr_val = 5'd1; run_cycle();
    chk(eoi_count == 5'd1, "R8 lower accepted", 32'(eoi_count), 1);
    cnt_wr = 1; cnt_wr_val = 5'd1; run_cycle();
    chk(eoi_count == 5'd1, "R8 hold accepted", 32'(eoi_count), 1);
    // R9 saturation
    repeat (34) begin deact_miss = 1; run_cycle(); end
    chk(eoi_count == 5'd31, "R9 saturate", 32'(eoi_count), 31);
    // R9 write and miss together
    cnt_wr = 1; cnt_wr_val = 5'd4; deact_miss = 1; run_cycle();
    chk(eoi_count == 5'd5, "R9 write plus miss", 32'(eoi_count), 5);
    cnt_wr = 1; cnt_wr_val = 5'd0; run_cycle();
    chk(cause[2] == 0, "R5 count zero", 32'(cause[2]), 0);

    // R6 and random mix
    for (int k = 0; k < 600; k++) begin
      lr_state = $urandom();
      if ($urandom_range(3) == 0) lr_state = lr_state & 32'h0000_000F;
      lr_hw = 16'($urandom()); lr_notify = 16'($urandom());
      {virt_en, en_underflow, en_nopend, en_notpresent} = 4'($urandom());
      {en_g0_on, en_g0_off, en_g1_on, en_g1_off, vgrp0_en, vgrp1_en} = 6'($urandom());
      cnt_wr = ($urandom_range(3) == 0);
      cnt_wr_val = 5'($urandom());
      deact_miss = ($urandom_range(2) == 0);
      run_cycle();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule